// File: doc/BRIEF.md
# Masked Address Window Translator

This unit sits on the outbound path of a bridge from a local bus to PCI memory space. Software programs four 32-bit registers through a plain register port: a local base address, a mask and attribute word, and the low and high words of the PCI target address. For every local request presented on the request channel, the unit decides whether the address falls inside the programmed window. It then forms the 32-bit PCI address and says whether a narrow read should be widened into a 64-byte prefetch.

The window size comes from the mask field in bits 31:12 of the mask and attribute word. Address bits where the mask is one take part in the hit compare and are replaced by the PCI low word. Bits where the mask is zero pass through unchanged. Bits 11:0 always pass through, so the smallest window is 4 KB.

The request path holds no state, so each request is answered in the same cycle. `rsp_valid` follows `req_valid` and `req_ready` follows `rsp_ready`. A downstream stall therefore reaches the requester in the same cycle, and nothing is held inside the unit. Register writes take effect at the next rising clock edge.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset every register reads zero, `mask_err` is low and no request hits.
- R2: While the window is enabled, a valid request hits exactly when its address equals the base register on every bit in 31:12 where the mask field is one; a zero mask field hits every address.
- R3: When bit 0 of the mask and attribute word (register select 1) is zero, `rsp_hit` stays low for every request.
- R4: On bits 31:12, `rsp_addr` takes the PCI low word where the mask is one and the request address where the mask is zero.
- R5: `rsp_addr[11:0]` always equals `req_addr[11:0]`.
- R6: The base register (select 0) and the PCI low word (select 2) store bits 31:12 and read bits 11:0 as zero.
- R7: The mask and attribute word (select 1) stores bits 31:12 and 1:0 and reads bits 11:2 as zero.
- R8: When bit 1 of the mask and attribute word is set, a hitting read of size code 0 (single beat), 1 (byte burst) or 2 (halfword burst) raises `rsp_prefetch`.
- R9: `rsp_prefetch` stays low for writes, for misses, for size codes 3 and above, and whenever bit 1 is clear.
- R10: A write to select 1 whose mask field is not a run of ones from bit 31 followed by zeros is stored as written and sets `mask_err`. The flag stays set until reset, and the raw mask still drives the compare and the splice.
- R11: `rsp_valid` equals `req_valid` and `req_ready` equals `rsp_ready`; while `req_valid` is low, `rsp_hit` and `rsp_prefetch` are low.
- R12: The PCI high word (select 3) stores all 32 bits, reads back unchanged and drives `rsp_addr_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 mask/attributes, 2 PCI low, 3 PCI high |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register, combinational |
| mask_err | output | 1 | Sticky flag for a non-contiguous mask write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted; mirrors `rsp_ready` |
| req_addr | input | 32 | Local request address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_size | input | 3 | Transfer code: 0 single, 1 byte burst, 2 halfword burst, 3 word burst, 4 and above wider |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Downstream accepts the result |
| rsp_hit | output | 1 | Request falls inside the enabled window |
| rsp_addr | output | 32 | Translated PCI address, low word |
| rsp_addr_hi | output | 32 | Stored PCI high address word |
| rsp_prefetch | output | 1 | Widen this read into a 64-byte prefetch |

## Verification
The assertions assume that `rst_n` is low through the first clock edges, so the registers start from known values. They also assume that the request and register inputs change only away from the rising edge. The bench changes every input shortly after the falling edge and samples one nanosecond later. Every size code, including the unused ones above 4, is a legal input, so the stimulus covers all of them. Register writes cover contiguous masks, non-contiguous masks and a zero mask, because the assertions place no limit on the mask value.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_BASE  = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_PCILO = 2'd2,
    SEL_PCIHI = 2'd3
  } cfg_sel_e;

  typedef enum logic [2:0] {
    XFER_SINGLE = 3'd0,
    XFER_BYTE   = 3'd1,
    XFER_HALF   = 3'd2,
    XFER_WORD   = 3'd3,
    XFER_WIDE   = 3'd4
  } xfer_e;

  localparam int unsigned ATTR_EN_BIT = 0;
  localparam int unsigned ATTR_PF_BIT = 1;
endpackage

// File: rtl/xlate_regfile.sv
module xlate_regfile
  import xlate_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12,
  localparam int unsigned PAGE_W   = ADDR_W - PAGE_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   sel,
  input  logic [ADDR_W-1:0]  wdata,
  output logic [ADDR_W-1:0]  rdata,
  output logic [PAGE_W-1:0]  base_pg,
  output logic [PAGE_W-1:0]  mask_pg,
  output logic [PAGE_W-1:0]  tgt_pg,
  output logic [ADDR_W-1:0]  tgt_hi,
  output logic               win_en,
  output logic               pf_en,
  output logic               err
);
  logic [PAGE_W-1:0] inv_m;
  logic              contig;

  assign inv_m  = ~wdata[ADDR_W-1:PAGE_BITS];
  assign contig = ((inv_m & (inv_m + 1'b1)) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_pg <= '0;
      mask_pg <= '0;
      tgt_pg  <= '0;
      tgt_hi  <= '0;
      win_en  <= 1'b0;
      pf_en   <= 1'b0;
      err     <= 1'b0;
    end else if (wr_en) begin
      unique case (cfg_sel_e'(sel))
        SEL_BASE:  base_pg <= wdata[ADDR_W-1:PAGE_BITS];
        SEL_MASK: begin
          mask_pg <= wdata[ADDR_W-1:PAGE_BITS];
          win_en  <= wdata[ATTR_EN_BIT];
          pf_en   <= wdata[ATTR_PF_BIT];
          if (!contig) err <= 1'b1;
        end
        SEL_PCILO: tgt_pg <= wdata[ADDR_W-1:PAGE_BITS];
        SEL_PCIHI: tgt_hi <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    unique case (cfg_sel_e'(sel))
      SEL_BASE:  rdata[ADDR_W-1:PAGE_BITS] = base_pg;
      SEL_MASK: begin
        rdata[ADDR_W-1:PAGE_BITS] = mask_pg;
        rdata[ATTR_EN_BIT]        = win_en;
        rdata[ATTR_PF_BIT]        = pf_en;
      end
      SEL_PCILO: rdata[ADDR_W-1:PAGE_BITS] = tgt_pg;
      SEL_PCIHI: rdata = tgt_hi;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/xlate_window.sv
module xlate_window #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12,
  localparam int unsigned PAGE_W   = ADDR_W - PAGE_BITS
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              valid,
  input  logic              win_en,
  input  logic [PAGE_W-1:0] base_pg,
  input  logic [PAGE_W-1:0] mask_pg,
  input  logic [PAGE_W-1:0] tgt_pg,
  output logic              hit,
  output logic [ADDR_W-1:0] xaddr
);
  logic [PAGE_W-1:0] diff;

  for (genvar b = 0; b < PAGE_W; b++) begin : g_bit
    assign diff[b]             = mask_pg[b] & (addr[PAGE_BITS+b] ^ base_pg[b]);
    assign xaddr[PAGE_BITS+b]  = mask_pg[b] ? tgt_pg[b] : addr[PAGE_BITS+b];
  end

  assign xaddr[PAGE_BITS-1:0] = addr[PAGE_BITS-1:0];
  assign hit = valid & win_en & ~(|diff);
endmodule

// File: rtl/xlate_prefetch.sv
module xlate_prefetch
  import xlate_pkg::*;
(
  input  logic       hit,
  input  logic       pf_en,
  input  logic       is_write,
  input  logic [2:0] size,
  output logic       pf_req
);
  logic narrow;

  always_comb begin
    unique case (xfer_e'(size))
      XFER_SINGLE, XFER_BYTE, XFER_HALF: narrow = 1'b1;
      default:                           narrow = 1'b0;
    endcase
  end

  assign pf_req = hit & pf_en & ~is_write & narrow;
endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
  import xlate_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  output logic              mask_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [2:0]        req_size,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [ADDR_W-1:0] rsp_addr_hi,
  output logic              rsp_prefetch
);
  localparam int unsigned PAGE_W = ADDR_W - PAGE_BITS;

  logic [PAGE_W-1:0] base_pg, mask_pg, tgt_pg;
  logic              win_en, pf_en, hit;

  xlate_regfile #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .base_pg(base_pg), .mask_pg(mask_pg), .tgt_pg(tgt_pg),
    .tgt_hi(rsp_addr_hi), .win_en(win_en), .pf_en(pf_en), .err(mask_err)
  );

  xlate_window #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) win_i (
    .addr(req_addr), .valid(req_valid), .win_en(win_en),
    .base_pg(base_pg), .mask_pg(mask_pg), .tgt_pg(tgt_pg),
    .hit(hit), .xaddr(rsp_addr)
  );

  xlate_prefetch pf_i (
    .hit(hit), .pf_en(pf_en), .is_write(req_write),
    .size(req_size), .pf_req(rsp_prefetch)
  );

  assign rsp_hit   = hit;
  assign rsp_valid = req_valid;
  assign req_ready = rsp_ready;
endmodule

// File: rtl/xlate_checker.sv
module xlate_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cfg_sel,
  input logic [31:0] cfg_rdata,
  input logic        mask_err,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic        req_write,
  input logic [2:0]  req_size,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_hit,
  input logic [31:0] rsp_addr,
  input logic        rsp_prefetch
);
  assert_handshake_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid == req_valid) && (req_ready == rsp_ready));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!rsp_hit && !rsp_prefetch));

  assert_pf_needs_hit_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_prefetch |-> (rsp_hit && !req_write && req_size < 3'd3));

  assert_low_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_addr[11:0] == req_addr[11:0]);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_err |=> mask_err);

  assert_page_regs_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == 2'd0 || cfg_sel == 2'd2) |-> (cfg_rdata[11:0] == 12'h0));

  assert_attr_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == 2'd1) |-> (cfg_rdata[11:2] == 10'h0));
endmodule

bind addr_window_xlate xlate_checker chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_rdata(cfg_rdata),
  .mask_err(mask_err), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
  .rsp_addr(rsp_addr), .rsp_prefetch(rsp_prefetch)
);

// File: tb/addr_window_xlate_tb_top.sv
module addr_window_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mask_err;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [2:0]  req_size = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic [31:0] rsp_addr;
  logic [31:0] rsp_addr_hi;
  logic        rsp_prefetch;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural model state
  logic [31:0] m_base = '0, m_mask = '0, m_lo = '0, m_hi = '0;
  bit          m_err = 1'b0;

  always #2 clk = ~clk;

  addr_window_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mask_err(mask_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
    .rsp_addr_hi(rsp_addr_hi), .rsp_prefetch(rsp_prefetch)
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit mask_ok(input logic [31:0] v);
    bit seen_zero = 1'b0;
    for (int i = 31; i >= 12; i--) begin
      if (!v[i]) seen_zero = 1'b1;
      else if (seen_zero) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic check_all();
    logic [31:0] mpg, exp_rd, exp_addr;
    bit e_hit, e_pf;
    mpg = m_mask & 32'hFFFF_F000;
    case (cfg_sel)
      2'd0: exp_rd = m_base;
      2'd1: exp_rd = m_mask;
      2'd2: exp_rd = m_lo;
      default: exp_rd = m_hi;
    endcase
    e_hit = req_valid && m_mask[0] && (((req_addr ^ m_base) & mpg) == 0);
    exp_addr = (m_lo & mpg) | (req_addr & ~mpg);
    e_pf = e_hit && m_mask[1] && !req_write && (req_size <= 3'd2);
    cmp(cfg_sel == 2'd1 ? "R7 rdata" : (cfg_sel == 2'd3 ? "R12 rdata" : "R6 rdata"), cfg_rdata, exp_rd);
    cmp("R10 mask_err", {31'b0, mask_err}, {31'b0, m_err});
    cmp("R11 rsp_valid", {31'b0, rsp_valid}, {31'b0, req_valid});
    cmp("R11 req_ready", {31'b0, req_ready}, {31'b0, rsp_ready});
    cmp("R2 hit", {31'b0, rsp_hit}, {31'b0, e_hit});
    cmp("R4 rsp_addr", rsp_addr, exp_addr);
    cmp("R12 rsp_addr_hi", rsp_addr_hi, m_hi);
    cmp("R8 prefetch", {31'b0, rsp_prefetch}, {31'b0, e_pf});
  endtask

  // one clock: drive after falling edge, sample 1 ns later, update model at rising edge
  task automatic cyc(input bit wr, input logic [1:0] sel, input logic [31:0] wd,
                     input bit v, input logic [31:0] a, input bit w, input logic [2:0] sz,
                     input bit rr);
    @(negedge clk);
    cfg_wr = wr; cfg_sel = sel; cfg_wdata = wd;
    req_valid = v; req_addr = a; req_write = w; req_size = sz; rsp_ready = rr;
    #1 check_all();
    @(posedge clk);
    if (wr) begin
      case (sel)
        2'd0: m_base = wd & 32'hFFFF_F000;
        2'd1: begin m_mask = wd & 32'hFFFF_F003; if (!mask_ok(wd)) m_err = 1'b1; end
        2'd2: m_lo = wd & 32'hFFFF_F000;
        default: m_hi = wd;
      endcase
    end
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [31:0] wd);
    cyc(1'b1, sel, wd, 1'b0, 32'h0, 1'b0, 3'd0, 1'b1);
  endtask

  task automatic rq(input logic [31:0] a, input bit w, input logic [2:0] sz);
    cyc(1'b0, 2'd1, 32'h0, 1'b1, a, w, sz, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state, all selects read zero, no hit even for valid requests
    for (int s = 0; s < 4; s++) cyc(1'b0, s[1:0], 32'h0, 1'b1, 32'h0000_0123, 1'b0, 3'd0, 1'b1);

    // program a 128 MB window with prefetch; R6/R7/R12 readback
    wreg(2'd0, 32'h4000_0FFF);
    wreg(2'd2, 32'h8000_0ABC);
    wreg(2'd3, 32'h1234_5678);
    wreg(2'd1, 32'hF800_0FFF);
    for (int s = 0; s < 4; s++) cyc(1'b0, s[1:0], 32'h0, 1'b0, 32'h0, 1'b0, 3'd0, 1'b1);

    // R2/R4/R5 hits and misses; R8 narrow reads; R9 writes and wide reads
    for (int sz = 0; sz < 8; sz++) rq(32'h4123_4567, 1'b0, sz[2:0]);
    rq(32'h47FF_FFFF, 1'b1, 3'd0);
    rq(32'h4800_0000, 1'b0, 3'd0);
    rq(32'h3FFF_FFFF, 1'b0, 3'd1);

    // R9: prefetch bit clear suppresses prefetch
    wreg(2'd1, 32'hF800_0001);
    rq(32'h4000_0010, 1'b0, 3'd0);

    // R3: window disabled never hits
    wreg(2'd1, 32'hF800_0002);
    rq(32'h4000_0010, 1'b0, 3'd0);
    rq(32'h4555_0000, 1'b0, 3'd2);

    // 4 KB window: only the exact page hits
    wreg(2'd1, 32'hFFFF_F003);
    rq(32'h4000_0FFC, 1'b0, 3'd0);
    rq(32'h4000_1000, 1'b0, 3'd0);

    // zero mask: all addresses hit and pass through (R2, R4)
    wreg(2'd1, 32'h0000_0003);
    rq(32'hDEAD_BEEF, 1'b0, 3'd1);

    // R10: non-contiguous mask stored raw, flag sticks across a later good write
    wreg(2'd1, 32'hF0F0_0001);
    rq(32'h4000_0000, 1'b0, 3'd0);
    rq(32'h4F0F_F000, 1'b0, 3'd0);
    wreg(2'd1, 32'hFF00_0001);
    rq(32'h40FF_0000, 1'b0, 3'd0);

    // R11: idle requests and back-pressure
    cyc(1'b0, 2'd3, 32'h0, 1'b0, 32'h40FF_0000, 1'b0, 3'd0, 1'b0);
    cyc(1'b0, 2'd0, 32'h0, 1'b1, 32'h40FF_0000, 1'b0, 3'd0, 1'b0);

    // random mix against the model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r1, r2;
      r1 = $urandom; r2 = $urandom;
      if (r1[3:0] == 4'd0) r2 = 32'hFFFF_FFFF << r1[8:4];
      if (r1[3:0] == 4'd1) r2 = m_base ^ {12'h0, r1[19:0]};
      cyc(r1[31:29] == 3'd0, r1[28:27], r1[3:0] == 4'd0 ? (r2 | {30'b0, r1[26:25]}) : r2,
          r1[24], r1[4] ? (m_base | (r2 & 32'h00FF_FFFF)) : r2, r1[23], r1[22:20], r1[21]);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule